// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sleep Handling

This block is the digital controller for a 10-bit successive-approximation converter inside a small microcontroller. Software programs it through a simple register port: an enable bit, a start/busy bit, a justification bit, a reference bit, a channel field and a conversion-clock select field. Once started, it counts conversion-clock periods, then stores the 10-bit code in a high/low pair of 8-bit result registers, clears the busy bit and sets an interrupt flag.

The conversion clock is either the system clock divided by a power of two or a free-running RC oscillator tick. That choice sets how the block reacts when the core goes to sleep. A conversion on a divided clock is dropped, because that clock stops. A conversion on the RC clock waits for one instruction-cycle strobe before it starts, so the core can execute its sleep instruction first. It then runs to the end while the core sleeps, and it can request a wake-up. In place of the analog comparator and DAC, a behavioural stub returns a preset code.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control register (address 0), the clock register (address 1) and the interrupt register (address 4) read 0x00, and wake_o is 0. In the control register, bit 7 selects right justification, bit 6 is the reference select, bits 4:2 are the channel and bit 1 is GO. Bit 0 is the enable. In the interrupt register, bit 0 is the flag and bit 1 is the interrupt enable.
- R2: A write with GO = 1 is ignored unless the enable bit was already 1 before that write. GO then reads back 0.
- R3: Clock code k (bits 6:4 of address 1, k = 0..6) makes the conversion clock the system clock divided by 2^(k+1). A conversion ends after 11 conversion-clock periods, and GO then reads 0.
- R4: With bit 7 = 0, address 2 reads result bits 9:2. Address 3 reads result bits 1:0 in its bits 7:6, with zeros below.
- R5: With bit 7 = 1, address 2 reads result bits 9:8 in its bits 1:0, with zeros above. Address 3 reads result bits 7:0.
- R6: Every completed conversion sets the flag, whatever the interrupt enable is. The flag stays set until software writes it 0. If completion and a software clear fall in the same cycle, the flag ends up set.
- R7: If sleep_i is high while a divided clock is selected and a conversion is pending, the conversion is dropped. GO clears, the results and the flag are unchanged, and the enable stays 1.
- R8: With clock code 7 (RC tick), a conversion does not start until an instruction strobe arrives after GO was set. RC ticks before that strobe are not counted.
- R9: An RC conversion keeps running and completes during sleep. If the interrupt enable is 1, wake_o pulses for one cycle. If it is 0, no wake pulse occurs and the enable stays 1.
- R10: Writing the enable bit to 0 during a conversion aborts it. The results are not updated and the flag is not set.
- R11: Reset returns the control, clock and interrupt registers to 0x00 and drops any pending conversion. The result registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| sleep_i | input | 1 | Core is in sleep |
| instr_stb_i | input | 1 | One-cycle strobe per instruction cycle |
| rc_tick_i | input | 1 | One-cycle tick from the RC oscillator, synchronous to clk_i |
| stub_code_i | input | 10 | Code the converter stub returns |
| wake_o | output | 1 | One-cycle wake request |
| flag_o | output | 1 | Conversion-complete flag |

## Verification
Two events can land on the same clock edge: hardware completing a conversion and setting the flag, and a software write that clears the flag. With the RC tick, the bench sets the exact edge of the eleventh tick, so it issues the clearing write in that cycle. It then requires the flag to read 1 afterwards, and it confirms that a later lone clear still works. The same tick control lets it check that ten ticks leave GO set, and that sleep entry on the RC clock does not abort the conversion, unlike on a divided clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_CONV = 2'd2
  } conv_st_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CLK  = 3'd1;
  localparam logic [2:0] A_RESH = 3'd2;
  localparam logic [2:0] A_RESL = 3'd3;
  localparam logic [2:0] A_IRQ  = 3'd4;
endpackage

// File: rtl/adc_clk_tick.sv
module adc_clk_tick #(
  parameter int unsigned CSEL_W = 3,
  parameter int unsigned DIV_W  = 8,
  parameter logic [CSEL_W-1:0] RC_SEL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSEL_W-1:0] csel_i,
  input  logic              rc_tick_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask_w;

  // bit g of the mask is set for g <= code, so divisor = 2^(code+1)
  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign mask_w[g] = (32'(g) <= 32'(csel_i));
  end

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    if (csel_i == RC_SEL) tick_o = rc_tick_i;
    else                  tick_o = ((cnt_q & mask_w) == mask_w);
  end
endmodule

// File: rtl/adc_sar_stub.sv
module adc_sar_stub #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned STEPS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] code_i,
  output logic             done_o,
  output logic [RES_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [RES_W-1:0] code_q;
  logic             code_en;

  always_comb begin
    cnt_en = !run_i || tick_i;
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
  end

  assign code_en = !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (code_en) code_q <= code_i;
    end
  end

  assign done_o = run_i && tick_i && (cnt_q == CNT_W'(STEPS - 1));
  assign code_o = code_q;
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 8
) (
  input  logic             right_i,
  input  logic [RES_W-1:0] code_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int unsigned SPILL = RES_W - REG_W;

  always_comb begin
    if (right_i) begin
      hi_o = {{(REG_W-SPILL){1'b0}}, code_i[RES_W-1:REG_W]};
      lo_o = code_i[REG_W-1:0];
    end else begin
      hi_o = code_i[RES_W-1:SPILL];
      lo_o = {code_i[SPILL-1:0], {(REG_W-SPILL){1'b0}}};
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned CSEL_W     = 3,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned CONV_STEPS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             sleep_i,
  input  logic             instr_stb_i,
  input  logic             rc_tick_i,
  input  logic [RES_W-1:0] stub_code_i,
  output logic             wake_o,
  output logic             flag_o
);
  localparam logic [CSEL_W-1:0] RC_SEL = '1;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  conv_st_e          st_q, st_d;
  logic              en_q, en_d, go_q, go_d;
  logic              fmt_q, fmt_d, vref_q, vref_d;
  logic [2:0]        chan_q, chan_d;
  logic [CSEL_W-1:0] csel_q, csel_d;
  logic              ie_q, ie_d, flag_q, flag_d, wake_q, wake_d;
  logic [REG_W-1:0]  resh_q, resl_q, fmt_hi, fmt_lo;
  logic              rc_sel, conv_tick, stub_done, conv_fin, conv_run;
  logic              ctrl_wr, sleep_abort;
  logic [RES_W-1:0]  stub_code;

  assign rc_sel   = (csel_q == RC_SEL);
  assign conv_run = (st_q == ST_CONV);
  assign ctrl_wr  = wr_en_i && (wr_addr_i == A_CTRL);

  adc_clk_tick #(.CSEL_W(CSEL_W), .DIV_W(DIV_W), .RC_SEL(RC_SEL)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .csel_i(csel_q),
    .rc_tick_i(rc_tick_i), .tick_o(conv_tick)
  );

  adc_sar_stub #(.RES_W(RES_W), .STEPS(CONV_STEPS)) u_stub (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .run_i(conv_run), .tick_i(conv_tick),
    .code_i(stub_code_i), .done_o(stub_done), .code_o(stub_code)
  );

  adc_result_fmt #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
    .right_i(fmt_q), .code_i(stub_code), .hi_o(fmt_hi), .lo_o(fmt_lo)
  );

  always_comb begin
    en_d = en_q; go_d = go_q; fmt_d = fmt_q; vref_d = vref_q; chan_d = chan_q;
    csel_d = csel_q; ie_d = ie_q; flag_d = flag_q; st_d = st_q;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL: begin
          fmt_d  = wr_data_i[7];
          vref_d = wr_data_i[6];
          chan_d = wr_data_i[4:2];
          en_d   = wr_data_i[0];
          go_d   = wr_data_i[1] && wr_data_i[0] && en_q;
        end
        A_CLK: csel_d = wr_data_i[4 +: CSEL_W];
        A_IRQ: begin
          flag_d = wr_data_i[0];
          ie_d   = wr_data_i[1];
        end
        default: ;
      endcase
    end
    // divided clock stops in sleep: pending conversion is dropped
    sleep_abort = sleep_i && !rc_sel && go_q;
    if (sleep_abort) go_d = 1'b0;
    conv_fin = stub_done && go_d;
    if (conv_fin) begin
      go_d   = 1'b0;
      flag_d = 1'b1;
    end
    wake_d = conv_fin && sleep_i && ie_q;
    unique case (st_q)
      ST_IDLE: if (go_d && !go_q) st_d = rc_sel ? ST_HOLD : ST_CONV;
      ST_HOLD: if (instr_stb_i) st_d = ST_CONV;
      ST_CONV: if (stub_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (!go_d) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= ST_IDLE; en_q <= 1'b0; go_q <= 1'b0; fmt_q <= 1'b0; vref_q <= 1'b0;
      chan_q <= '0; csel_q <= '0; ie_q <= 1'b0; flag_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      st_q <= st_d; en_q <= en_d; go_q <= go_d; fmt_q <= fmt_d; vref_q <= vref_d;
      chan_q <= chan_d; csel_q <= csel_d; ie_q <= ie_d; flag_q <= flag_d; wake_q <= wake_d;
    end
  end

  // result pair has no reset: contents survive a device reset
  always_ff @(posedge clk_i) begin
    if (conv_fin) begin
      resh_q <= fmt_hi;
      resl_q <= fmt_lo;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = {fmt_q, vref_q, 1'b0, chan_q, go_q, en_q};
      A_CLK:   rd_data_o = 8'({csel_q, 4'b0000});
      A_RESH:  rd_data_o = resh_q;
      A_RESL:  rd_data_o = resl_q;
      A_IRQ:   rd_data_o = {6'b0, ie_q, flag_q};
      default: rd_data_o = 8'h00;
    endcase
  end

  assign wake_o = wake_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_q,
  input logic go_q,
  input logic ie_q,
  input logic flag_q,
  input logic conv_fin,
  input logic stub_done,
  input logic wake_o,
  input logic sleep_i,
  input logic rc_sel,
  input logic ctrl_wr
);
  // R2
  go_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> en_q);

  // R7
  sleep_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !rc_sel && go_q) |=> !go_q);

  // R7
  sleep_keeps_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !rc_sel && go_q && en_q && !ctrl_wr) |=> en_q);

  // R6
  fin_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_fin |=> flag_q);

  // R9
  wake_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(ie_q) && $past(sleep_i)));

  // R3
  done_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_fin |-> (go_q && stub_done));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .en_q(en_q), .go_q(go_q), .ie_q(ie_q),
  .flag_q(flag_q), .conv_fin(conv_fin), .stub_done(stub_done), .wake_o(wake_o),
  .sleep_i(sleep_i), .rc_sel(rc_sel), .ctrl_wr(ctrl_wr)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  localparam logic [2:0] AC = 3'd0, AK = 3'd1, AH = 3'd2, AL = 3'd3, AI = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sleep = 1'b0, instr = 1'b0, rc = 1'b0;
  logic [9:0] code = '0;
  logic       wake, flag;
  int         checks = 0, errors = 0, wake_cnt = 0;
  logic [7:0] last_h, last_l;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sleep_i(sleep), .instr_stb_i(instr), .rc_tick_i(rc),
    .stub_code_i(code), .wake_o(wake), .flag_o(flag)
  );

  always @(negedge clk) if (wake === 1'b1) wake_cnt++;

  function automatic logic [7:0] exp_hi(logic [9:0] c, bit right);
    return right ? {6'b0, c[9:8]} : c[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(logic [9:0] c, bit right);
    return right ? c[7:0] : {c[1:0], 6'b0};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rc_ticks(int n);
    repeat (n) begin
      @(negedge clk); rc = 1'b1;
      @(negedge clk); rc = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_instr();
    @(negedge clk); instr = 1'b1;
    @(negedge clk); instr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(AC, d); check("R1 ctrl", 16'(d), 16'h00);
    rd(AK, d); check("R1 clk", 16'(d), 16'h00);
    rd(AI, d); check("R1 irq", 16'(d), 16'h00);
    check("R1 wake", 16'(wake), 16'h0);

    // R2 go ignored without prior enable
    wr(AC, 8'h02); rd(AC, d); check("R2 go alone", 16'(d), 16'h00);
    wr(AC, 8'h03); rd(AC, d); check("R2 go with enable", 16'(d), 16'h01);
    rd(AI, d); check("R2 no flag", 16'(d), 16'h00);

    // R3/R4/R5/R6 divided-clock conversions
    for (int i = 0; i < 8; i++) begin
      int div;
      bit right, ie, done;
      logic [2:0] k;
      k = 3'($urandom_range(0, 3));
      div = 2 << k;
      right = (i % 2) == 1;
      ie = 1'($urandom);
      code = (i == 0) ? 10'h3FF : (i == 1) ? 10'h001 : 10'($urandom);
      wr(AI, {6'b0, ie, 1'b0});
      wr(AK, {1'b0, k, 4'b0});
      wr(AC, {right, 7'h01});
      wr(AC, {right, 7'h03});
      repeat (10 * div - 1) @(negedge clk);
      rd(AC, d); check("R3 busy before 11 periods", 16'(d[1]), 16'h1);
      done = 1'b0;
      for (int c = 0; c < 3 * div + 8; c++) begin
        rd(AC, d);
        if (d[1] == 1'b0) begin done = 1'b1; break; end
        @(negedge clk);
      end
      check("R3 completes", 16'(done), 16'h1);
      rd(AH, d); check(right ? "R5 high" : "R4 high", 16'(d), 16'(exp_hi(code, right)));
      last_h = d;
      rd(AL, d); check(right ? "R5 low" : "R4 low", 16'(d), 16'(exp_lo(code, right)));
      last_l = d;
      rd(AI, d); check("R6 flag set", 16'(d[0]), 16'h1);
      repeat (5) @(negedge clk);
      rd(AI, d); check("R6 flag holds", 16'(d[0]), 16'h1);
      wr(AI, {6'b0, ie, 1'b0});
      rd(AI, d); check("R6 flag cleared", 16'(d[0]), 16'h0);
    end

    // R10 disable aborts
    code = 10'h155;
    wr(AK, 8'h30); wr(AC, 8'h01); wr(AC, 8'h03);
    repeat (20) @(negedge clk);
    wr(AC, 8'h00);
    rd(AC, d); check("R10 ctrl after abort", 16'(d), 16'h00);
    repeat (300) @(negedge clk);
    rd(AI, d); check("R10 no flag", 16'(d[0]), 16'h0);
    rd(AH, d); check("R10 high kept", 16'(d), 16'(last_h));
    rd(AL, d); check("R10 low kept", 16'(d), 16'(last_l));

    // R7 sleep with divided clock aborts
    wr(AI, 8'h02);
    wr(AK, 8'h20); wr(AC, 8'h01); wr(AC, 8'h03);
    repeat (10) @(negedge clk);
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    rd(AC, d); check("R7 go cleared, enable kept", 16'(d), 16'h01);
    repeat (200) @(negedge clk);
    rd(AI, d); check("R7 no flag", 16'(d[0]), 16'h0);
    check("R7 no wake", 16'(wake_cnt), 16'h0);
    rd(AH, d); check("R7 high kept", 16'(d), 16'(last_h));
    rd(AL, d); check("R7 low kept", 16'(d), 16'(last_l));
    sleep = 1'b0;

    // R8/R9 RC clock, sleep, interrupt enabled then disabled
    for (int p = 0; p < 2; p++) begin
      bit ie;
      int w0;
      ie = (p == 0);
      code = (p == 0) ? 10'h2C7 : 10'h0B5;
      wr(AI, {6'b0, ie, 1'b0});
      wr(AK, 8'h70); wr(AC, 8'h81); wr(AC, 8'h83);
      rc_ticks(20);
      rd(AC, d); check("R8 held until strobe", 16'(d[1]), 16'h1);
      rd(AI, d); check("R8 no flag", 16'(d[0]), 16'h0);
      sleep = 1'b1;
      pulse_instr();
      rc_ticks(10);
      rd(AC, d); check("R9 busy after 10 ticks in sleep", 16'(d[1]), 16'h1);
      w0 = wake_cnt;
      rc_ticks(1);
      rd(AC, d); check("R9 done, enable kept", 16'(d), 16'h81);
      rd(AI, d); check("R9 flag", 16'(d[0]), 16'h1);
      check("R9 wake count", 16'(wake_cnt - w0), ie ? 16'h1 : 16'h0);
      rd(AH, d); check("R5 rc high", 16'(d), 16'(exp_hi(code, 1'b1)));
      rd(AL, d); check("R5 rc low", 16'(d), 16'(exp_lo(code, 1'b1)));
      sleep = 1'b0;
    end

    // R6 completion and software clear in the same cycle
    code = 10'h1E4;
    wr(AC, 8'h01); wr(AC, 8'h03);
    pulse_instr();
    rc_ticks(10);
    @(negedge clk); rc = 1'b1; wr_en = 1'b1; wr_addr = AI; wr_data = 8'h00;
    @(negedge clk); rc = 1'b0; wr_en = 1'b0;
    rd(AI, d); check("R6 set wins over clear", 16'(d[0]), 16'h1);
    rd(AH, d); check("R4 rc high", 16'(d), 16'(exp_hi(code, 1'b0)));
    last_h = d;
    rd(AL, d); check("R4 rc low", 16'(d), 16'(exp_lo(code, 1'b0)));
    last_l = d;
    wr(AI, 8'h00); rd(AI, d); check("R6 later clear", 16'(d[0]), 16'h0);

    // R11 reset mid-conversion keeps results
    code = 10'h0F0;
    wr(AK, 8'h30); wr(AC, 8'h01); wr(AC, 8'h03);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    rd(AC, d); check("R11 ctrl", 16'(d), 16'h00);
    rd(AK, d); check("R11 clk", 16'(d), 16'h00);
    rd(AI, d); check("R11 irq", 16'(d), 16'h00);
    rd(AH, d); check("R11 high kept", 16'(d), 16'(last_h));
    rd(AL, d); check("R11 low kept", 16'(d), 16'(last_l));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule